// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates 32 maskable interrupt lines and one non-maskable line on behalf of a processor core. Each maskable line feeds a pending bit. A parameter picks, line by line, whether a line is sensed as a held level or as a rising-edge pulse. Software reaches the enable and pending state through register pairs in which one register sets bits and the other clears them. It also gives every line a two-bit urgency code. The controller finds the most urgent request that is both enabled and pending. If that request outranks what the core is already servicing, it presents the line number and a request flag.

The core answers with an acknowledge, which activates the presented line and clears its pending bit. When a handler finishes, the core signals completion with the line number. The controller drops that line from the active set. If another eligible request is waiting, it asserts the request again in the very next cycle, so the core can chain straight into the next handler. The non-maskable line has its own request and acknowledge. It cannot be disabled, and while it is outstanding no maskable request is shown.

Top module: `vic32`

## Requirements
- R1: After reset all enable, pending and priority registers read 0, and neither `irq_req` nor `nmi_req` is asserted.
- R2: A write to offset 0x100 sets every enable bit written as 1, and a write to offset 0x180 clears every enable bit written as 1. Bits written as 0 are unchanged. Reads of either offset return the enable vector, with bit n belonging to line n.
- R3: Offsets 0x200 (set) and 0x280 (clear) act the same way on the pending vector.
- R4: The eight priority words sit at 0x400 + 4*w. Byte b of word w holds line 4w+b, and only bits [7:6] of that byte are stored. The other bits read 0.
- R5: `irq_req` presents the enabled pending line with the numerically smallest priority. Among lines of equal priority the lowest line number wins, and `irq_num` carries the winner.
- R6: On a pulse line, a rising input sets the pending bit, and the bit stays set after the input falls.
- R7: A level line sets its pending bit while the input is high and the line is not active. The bit stays clear while its handler runs. It is set again after return if the input is still high.
- R8: An acknowledge activates the presented line and clears its pending bit. A pending line causes a request only if its priority is strictly smaller than that of every active line.
- R9: After a completion, an eligible waiting request is asserted in the next cycle with no idle cycle.
- R10: A rising `nmi_in` asserts `nmi_req` until `nmi_ack`. The enable state has no effect on it, and `irq_req` stays low while it is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_in | input | 32 | Interrupt request lines |
| nmi_in | input | 1 | Non-maskable request line |
| irq_req | output | 1 | A maskable request is presented |
| irq_num | output | 5 | Number of the presented line |
| irq_ack | input | 1 | Core takes the presented line |
| irq_done | input | 1 | Core finished a handler |
| irq_done_num | input | 5 | Line whose handler finished |
| nmi_req | output | 1 | Non-maskable request outstanding |
| nmi_ack | input | 1 | Core takes the non-maskable request |

## Verification
The bench targets equal-priority ties. A selector that broke them toward the higher number would present line 7 instead of 5. It also checks that a same-priority request cannot preempt; a `<=` in place of `<` would raise a request while line 5 is active. A level line that is still high at return must pend again, and a design that lost it would never chain back into it. A pulse line must keep its pending bit after the input drops, and a design that followed the input would lose it. The bench also covers completion followed by a waiting request, where an extra idle cycle shows up as a model mismatch. It disables every line while the non-maskable request is pending, and a design that masked that request with the enables would drop `nmi_req`.

// File: rtl/vic32.sv
`timescale 1ns/1ps
module vic32 #(
  parameter logic [31:0] LEVEL_MASK = 32'hFFFF_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] irq_in,
  input  logic        nmi_in,
  output logic        irq_req,
  output logic [4:0]  irq_num,
  input  logic        irq_ack,
  input  logic        irq_done,
  input  logic [4:0]  irq_done_num,
  output logic        nmi_req,
  input  logic        nmi_ack
);
  localparam int NIRQ = 32;
  localparam int PW   = 2;
  localparam int NW   = $clog2(NIRQ);

  logic [NIRQ-1:0] en_q, pend_q, act_q, in_q;
  logic [PW-1:0]   prio_q [NIRQ];
  logic            nmi_q, nmi_pend;

  wire wr_ens = bus_we && bus_addr == 12'h100;
  wire wr_enc = bus_we && bus_addr == 12'h180;
  wire wr_pds = bus_we && bus_addr == 12'h200;
  wire wr_pdc = bus_we && bus_addr == 12'h280;
  wire in_pri = bus_addr[11:5] == 7'h20 && bus_addr[1:0] == 2'b00;
  wire wr_pri = bus_we && in_pri;

  logic [PW:0]   best_p, run_p;
  logic [NW-1:0] best_n;

  always_comb begin
    best_p = 3'd4;
    best_n = '0;
    for (int i = NIRQ-1; i >= 0; i--)
      if (pend_q[i] && en_q[i] && {1'b0, prio_q[i]} <= best_p) begin
        best_p = {1'b0, prio_q[i]};
        best_n = NW'(i);
      end
  end

  always_comb begin
    run_p = 3'd4;
    for (int i = 0; i < NIRQ; i++)
      if (act_q[i] && {1'b0, prio_q[i]} < run_p) run_p = {1'b0, prio_q[i]};
  end

  assign irq_req = (best_p < run_p) && !nmi_pend;
  assign irq_num = best_n;
  assign nmi_req = nmi_pend;

  wire [NIRQ-1:0] ack_mask  = (irq_ack && irq_req) ? (NIRQ'(1) << irq_num) : '0;
  wire [NIRQ-1:0] done_mask = irq_done ? (NIRQ'(1) << irq_done_num) : '0;
  wire [NIRQ-1:0] hw_set    = (irq_in & ~in_q & ~LEVEL_MASK)
                            | (irq_in & LEVEL_MASK & ~act_q & ~ack_mask);
  wire [NIRQ-1:0] sw_set    = wr_pds ? bus_wdata : '0;
  wire [NIRQ-1:0] sw_clr    = wr_pdc ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      pend_q   <= '0;
      act_q    <= '0;
      in_q     <= '0;
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      in_q  <= irq_in;
      nmi_q <= nmi_in;
      if (wr_ens) en_q <= en_q | bus_wdata;
      else if (wr_enc) en_q <= en_q & ~bus_wdata;
      pend_q   <= ((pend_q | sw_set) & ~(sw_clr | ack_mask)) | hw_set;
      act_q    <= (act_q & ~done_mask) | ack_mask;
      nmi_pend <= (nmi_pend && !nmi_ack) || (nmi_in && !nmi_q);
    end
  end

  generate
    for (genvar g = 0; g < NIRQ; g++) begin : g_prio
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prio_q[g] <= '0;
        else if (wr_pri && bus_addr[4:2] == 3'(g / 4))
          prio_q[g] <= bus_wdata[(g % 4) * 8 + 6 +: PW];
      end
    end
  endgenerate

  logic [31:0] pri_word;
  always_comb begin
    pri_word = '0;
    for (int b = 0; b < 4; b++)
      pri_word[b*8+6 +: PW] = prio_q[{bus_addr[4:2], 2'(b)}];
  end

  always_comb begin
    case (bus_addr)
      12'h100, 12'h180: bus_rdata = en_q;
      12'h200, 12'h280: bus_rdata = pend_q;
      default:          bus_rdata = in_pri ? pri_word : '0;
    endcase
  end

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !bus_we && !irq_in[irq_num]) |=> !pend_q[$past(irq_num)]);
  a_r8_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !irq_done) |=> act_q[$past(irq_num)]);
  a_r10_nmi_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_in && !nmi_q) |=> nmi_req);
  a_r10_nmi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !nmi_ack) |=> (nmi_req && !irq_req));
endmodule

// File: tb/vic32_bench.sv
`timescale 1ns/1ps
module vic32_bench;
  localparam logic [31:0] LVL = 32'hFFFF_0000;
  logic clk = 0, rst_n = 0;
  logic [11:0] bus_addr = 0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [31:0] irq_in = 0;
  logic nmi_in = 0, irq_req, irq_ack = 0, irq_done = 0, nmi_req, nmi_ack = 0;
  logic [4:0] irq_num, irq_done_num = 0;
  int checks = 0, fails = 0;
  string phase = "R5";

  always #2 clk = ~clk;

  vic32 #(.LEVEL_MASK(LVL)) u_vic32 (.*);

  bit [31:0] m_en, m_pend, m_act, m_inq;
  int m_pri[32];
  bit m_nq, m_np;

  function automatic void m_best(output bit req, output int num);
    int bp = 9, rp = 9;
    num = 0;
    for (int i = 0; i < 32; i++) begin
      if (m_act[i] && m_pri[i] < rp) rp = m_pri[i];
      if (m_pend[i] && m_en[i] && m_pri[i] < bp) begin bp = m_pri[i]; num = i; end
    end
    req = (bp < rp) && !m_np;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pend = 0; m_act = 0; m_inq = 0; m_nq = 0; m_np = 0;
      for (int i = 0; i < 32; i++) m_pri[i] = 0;
    end else begin
      bit r; int n; bit [31:0] ackm, nxt;
      m_best(r, n);
      ackm = (irq_ack && r) ? (32'd1 << n) : 0;
      if (bus_we) begin
        if (bus_addr == 12'h100) m_en = m_en | bus_wdata;
        if (bus_addr == 12'h180) m_en = m_en & ~bus_wdata;
        if (bus_addr >= 12'h400 && bus_addr <= 12'h41C && bus_addr[1:0] == 0)
          for (int b = 0; b < 4; b++) m_pri[(bus_addr - 12'h400) + b] = bus_wdata[b*8+6 +: 2];
      end
      nxt = m_pend;
      for (int i = 0; i < 32; i++) begin
        if (bus_we && bus_addr == 12'h200 && bus_wdata[i]) nxt[i] = 1;
        if (bus_we && bus_addr == 12'h280 && bus_wdata[i]) nxt[i] = 0;
        if (ackm[i]) nxt[i] = 0;
        if (!LVL[i] && irq_in[i] && !m_inq[i]) nxt[i] = 1;
        if (LVL[i] && irq_in[i] && !m_act[i] && !ackm[i]) nxt[i] = 1;
      end
      m_pend = nxt;
      if (irq_done) m_act[irq_done_num] = 0;
      m_act = m_act | ackm;
      m_inq = irq_in;
      m_np = (m_np && !nmi_ack) || (nmi_in && !m_nq);
      m_nq = nmi_in;
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit r; int n;
    m_best(r, n);
    checks++;
    if (irq_req !== r || nmi_req !== m_np || (r && irq_num !== 5'(n))) begin
      fails++;
      $display("FAIL %s cycle model: req=%0b num=%0d nmi=%0b expected req=%0b num=%0d nmi=%0b",
               phase, irq_req, irq_num, nmi_req, r, n, m_np);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
    @(negedge clk);
  endtask

  task automatic ack();
    irq_ack = 1; @(posedge clk); @(negedge clk); irq_ack = 0;
  endtask

  task automatic done(input int n);
    irq_done = 1; irq_done_num = 5'(n); @(posedge clk); @(negedge clk); irq_done = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R1";
    rd("R1 enable", 12'h100, 0);
    rd("R1 pending", 12'h200, 0);
    rd("R1 priority", 12'h41C, 0);
    chk("R1 req", {30'd0, irq_req, nmi_req}, 0);

    phase = "R2";
    wr(12'h100, 32'h0000_00F5);
    rd("R2 set view", 12'h100, 32'h0000_00F5);
    rd("R2 clear view", 12'h180, 32'h0000_00F5);
    wr(12'h180, 32'h0000_0005);
    rd("R2 clear ones", 12'h100, 32'h0000_00F0);
    wr(12'h100, 32'h0);
    rd("R2 zero no effect", 12'h100, 32'h0000_00F0);
    wr(12'h180, 32'h0);
    rd("R2 zero clear no effect", 12'h180, 32'h0000_00F0);
    wr(12'h100, 32'hFFFF_FFFF);

    phase = "R4";
    wr(12'h400, 32'hFFFF_FFFF);
    rd("R4 field mask", 12'h400, 32'hC0C0_C0C0);
    rd("R4 other word", 12'h404, 32'h0);
    wr(12'h400, 32'h0);

    phase = "R3";
    wr(12'h200, 32'h0000_0300);
    rd("R3 set view", 12'h200, 32'h0000_0300);
    rd("R3 clear view", 12'h280, 32'h0000_0300);
    wr(12'h280, 32'h0000_0100);
    rd("R3 clear ones", 12'h200, 32'h0000_0200);
    wr(12'h280, 32'h0000_0200);
    rd("R3 cleared", 12'h200, 32'h0);

    phase = "R5";
    wr(12'h400, 32'h8000_0000);
    wr(12'h404, 32'h4000_4000);
    wr(12'h200, 32'h0000_00A8);
    chk("R5 tie lowest number", {26'd0, irq_req, irq_num}, {26'd0, 1'b1, 5'd5});
    phase = "R8";
    ack();
    chk("R8 equal priority no preempt", {31'd0, irq_req}, 0);
    rd("R8 pending cleared", 12'h200, 32'h0000_0088);
    phase = "R9";
    done(5);
    chk("R9 chained request", {26'd0, irq_req, irq_num}, {26'd0, 1'b1, 5'd7});
    ack(); done(7);
    chk("R5 lower priority next", {26'd0, irq_req, irq_num}, {26'd0, 1'b1, 5'd3});
    ack();
    phase = "R8";
    wr(12'h200, 32'h0000_0020);
    chk("R8 strict preempt", {26'd0, irq_req, irq_num}, {26'd0, 1'b1, 5'd5});
    ack(); done(5); done(3);
    chk("R8 idle", {31'd0, irq_req}, 0);

    phase = "R6";
    irq_in[2] = 1; @(posedge clk); @(negedge clk); irq_in[2] = 0;
    @(negedge clk);
    rd("R6 pulse sticky", 12'h200, 32'h0000_0004);
    chk("R6 request", {26'd0, irq_req, irq_num}, {26'd0, 1'b1, 5'd2});
    ack(); done(2);

    phase = "R7";
    irq_in[20] = 1; @(negedge clk); @(negedge clk);
    rd("R7 level pends", 12'h200, 32'h0010_0000);
    ack();
    rd("R7 clear while active", 12'h200, 32'h0);
    done(20); @(negedge clk);
    rd("R7 repend on return", 12'h200, 32'h0010_0000);
    irq_in[20] = 0;
    wr(12'h280, 32'h0010_0000);
    rd("R7 cleared", 12'h200, 32'h0);

    phase = "R10";
    wr(12'h200, 32'h0000_0002);
    nmi_in = 1; @(negedge clk);
    chk("R10 nmi wins", {30'd0, nmi_req, irq_req}, 32'd2);
    wr(12'h180, 32'hFFFF_FFFF);
    chk("R10 enables ignored", {31'd0, nmi_req}, 1);
    nmi_ack = 1; @(posedge clk); @(negedge clk); nmi_ack = 0;
    chk("R10 nmi taken", {31'd0, nmi_req}, 0);
    nmi_in = 0;
    wr(12'h100, 32'hFFFF_FFFF);
    chk("R10 maskable resumes", {26'd0, irq_req, irq_num}, {26'd0, 1'b1, 5'd1});
    ack(); done(1);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule